// File: doc/BRIEF.md
# USB Endpoint Status Tracker

This block holds the transfer state of eight device-side USB endpoints. Endpoint 0 is the control endpoint; endpoints 1 to 7 become usable once a configuration names them. Upstream logic decodes the traffic on the bus and presents each protocol event as a one-cycle strobe. Token, data and transmit events carry an endpoint number. Configuration, FIFO initialization and stall requests carry a per-endpoint mask.

From these events each endpoint keeps a 3-bit status that firmware can read at any time. On the clock edge after an event, the block also produces the handshake decision for the addressed endpoint and one-cycle FULL or EMPTY interrupt pulses. Error outcomes change the status but never raise an interrupt. The rules for leaving STALL and INVALID depend on whether the endpoint is the control endpoint.

Top module: `usb_ep_status_tracker`

## Requirements
- R1: Status codes are 000 READY, 001 DATAIN, 010 FULL, 011 TX_ERR, 100 RX_ERR, 101 BUSY, 110 STALL, 111 INVALID. Endpoint i appears on `ep_status_o[3*i+2:3*i]`. After reset, asynchronous or not, every endpoint reads INVALID.
- R2: An INVALID endpoint gives no response (handshake 00) to tokens or data, raises no interrupt, and ignores stall requests and FIFO initialization.
- R3: A bus reset puts endpoint 0 in READY and endpoints 1 to 7 in INVALID. It wins over every event in the same cycle.
- R4: A set bit of `cfg_mask_i` moves endpoints 1 to 7 to READY from any state. Bit 0 has no effect.
- R5: A set bit of `stall_req_i` moves a non-INVALID endpoint to STALL.
- R6: Token types are 00 OUT, 01 IN and 10 SETUP. An endpoint in STALL answers any token other than SETUP with handshake 11 (STALL). A SETUP token gets no STALL answer.
- R7: Endpoint 0 leaves STALL for READY only on a SETUP token, and ignores FIFO initialization. Endpoints 1 to 7 leave STALL only on FIFO initialization, and a SETUP token leaves them in STALL.
- R8: Good received data sets the endpoint to DATAIN, answers handshake 01 (ACK) and pulses that endpoint's FULL interrupt.
- R9: Received data with an error sets RX_ERR, answers 00 and raises no interrupt. A later good packet moves the endpoint to DATAIN.
- R10: An IN transmit that times out without an ACK sets TX_ERR with no interrupt. A transmit acknowledged by the host sets READY and pulses that endpoint's EMPTY interrupt.
- R11: Only endpoint 0 uses BUSY. A status-stage token enters BUSY and a clean status-stage completion returns to READY. Good data while BUSY is answered 10 (NAK) with no status change. Endpoints 1 to 7 ignore both status-stage strobes.
- R12: Status, handshake and interrupts are registered and change on the first clock edge after the event. Handshake and interrupts last one cycle, and at most one interrupt bit is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_ep_i | input | 3 | Endpoint addressed by token, data, transmit and status-stage strobes |
| tok_valid_i | input | 1 | Token strobe |
| tok_type_i | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP |
| rx_ok_i | input | 1 | Data packet received without error |
| rx_err_i | input | 1 | Data packet received with an error |
| tx_ack_i | input | 1 | Transmitted data acknowledged by the host |
| tx_timeout_i | input | 1 | Transmitted data not acknowledged |
| stage_tok_i | input | 1 | Status-stage token after the data stage |
| stage_done_i | input | 1 | Status stage completed without error |
| bus_reset_i | input | 1 | USB bus reset detected |
| cfg_mask_i | input | 8 | Configuration applied, one bit per endpoint |
| fifo_init_i | input | 8 | FIFO initialization command, one bit per endpoint |
| stall_req_i | input | 8 | Firmware stall request, one bit per endpoint |
| ep_status_o | output | 24 | Packed 3-bit status of each endpoint |
| hs_o | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| full_irq_o | output | 8 | FULL interrupt pulse per endpoint |
| empty_irq_o | output | 8 | EMPTY interrupt pulse per endpoint |

## Verification
The assertions watch a set of properties on every cycle:
- An interrupt pulse always comes with the matching DATAIN or READY status.
- A STALL answer comes only from an endpoint that is in STALL.
- An INVALID endpoint stays silent.
- The cycle after a bus reset holds the reset outcome.
- At most one interrupt bit is set at a time.

The bench scenarios are needed for the rest:
- The different exit paths from STALL for the control endpoint and for the others.
- Recovery from the two error states.
- The NAK answer during BUSY.
- The rule that configuration bit 0 is ignored.
- The priority of a bus reset over a stall request that arrives in the same cycle.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [2:0] {
    ST_READY   = 3'b000,
    ST_DATAIN  = 3'b001,
    ST_FULL    = 3'b010,
    ST_TX_ERR  = 3'b011,
    ST_RX_ERR  = 3'b100,
    ST_BUSY    = 3'b101,
    ST_STALL   = 3'b110,
    ST_INVALID = 3'b111
  } ep_st_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10,
    TOK_RSVD  = 2'b11
  } tok_e;

  localparam int unsigned ST_W = 3;
  localparam int unsigned HS_W = 2;
endpackage

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
  import usb_ep_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_i,
  input  logic   tok_valid_i,
  input  tok_e   tok_type_i,
  input  logic   rx_ok_i,
  input  logic   rx_err_i,
  input  logic   tx_ack_i,
  input  logic   tx_timeout_i,
  input  logic   stage_tok_i,
  input  logic   stage_done_i,
  input  logic   bus_reset_i,
  input  logic   cfg_i,
  input  logic   fifo_init_i,
  input  logic   stall_req_i,
  output ep_st_e st_o,
  output hs_e    hs_o,
  output logic   full_o,
  output logic   empty_o
);
  ep_st_e st_q, st_d;
  hs_e    hs_q, hs_d;
  logic   full_q, full_d, empty_q, empty_d;

  always_comb begin
    st_d    = st_q;
    hs_d    = HS_NONE;
    full_d  = 1'b0;
    empty_d = 1'b0;
    if (bus_reset_i) begin
      st_d = IS_CTRL ? ST_READY : ST_INVALID;
    end else if (st_q == ST_INVALID) begin
      if (!IS_CTRL && cfg_i) st_d = ST_READY;
    end else if (stall_req_i) begin
      st_d = ST_STALL;
    end else if (!IS_CTRL && cfg_i) begin
      st_d = ST_READY;
    end else if (st_q == ST_STALL) begin
      if (sel_i && tok_valid_i) begin
        if (tok_type_i == TOK_SETUP) begin
          if (IS_CTRL) st_d = ST_READY;
        end else begin
          hs_d = HS_STALL;
        end
      end else if (!IS_CTRL && fifo_init_i) begin
        st_d = ST_READY;
      end
    end else if (sel_i) begin
      if (rx_err_i) begin
        st_d = ST_RX_ERR;
      end else if (rx_ok_i) begin
        if (IS_CTRL && st_q == ST_BUSY) begin
          hs_d = HS_NAK;  // status stage owns the pipe
        end else begin
          st_d   = ST_DATAIN;
          hs_d   = HS_ACK;
          full_d = 1'b1;
        end
      end else if (tx_timeout_i) begin
        st_d = ST_TX_ERR;
      end else if (tx_ack_i) begin
        st_d    = ST_READY;
        empty_d = 1'b1;
      end else if (IS_CTRL && stage_tok_i) begin
        st_d = ST_BUSY;
      end else if (IS_CTRL && stage_done_i && st_q == ST_BUSY) begin
        st_d = ST_READY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_INVALID;
      hs_q    <= HS_NONE;
      full_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      hs_q    <= hs_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign st_o    = st_q;
  assign hs_o    = hs_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;

  // R8
  full_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> st_q == ST_DATAIN);
  // R10
  empty_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_q |-> st_q == ST_READY);
  // R6
  stall_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_q == HS_STALL |-> st_q == ST_STALL);
  // R3
  bus_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> st_q == (IS_CTRL ? ST_READY : ST_INVALID));
  // R2
  invalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INVALID && !bus_reset_i) |=> (hs_q == HS_NONE && !full_q && !empty_q));
endmodule

// File: rtl/usb_ep_hs_merge.sv
module usb_ep_hs_merge #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 2
) (
  input  logic [N*W-1:0] hs_all_i,
  output logic [W-1:0]   hs_o
);
  always_comb begin
    hs_o = '0;
    for (int i = 0; i < N; i++) hs_o |= hs_all_i[i*W +: W];
  end
endmodule

// File: rtl/usb_ep_status_tracker.sv
module usb_ep_status_tracker
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [EP_W-1:0]        ev_ep_i,
  input  logic                   tok_valid_i,
  input  logic [1:0]             tok_type_i,
  input  logic                   rx_ok_i,
  input  logic                   rx_err_i,
  input  logic                   tx_ack_i,
  input  logic                   tx_timeout_i,
  input  logic                   stage_tok_i,
  input  logic                   stage_done_i,
  input  logic                   bus_reset_i,
  input  logic [NUM_EP-1:0]      cfg_mask_i,
  input  logic [NUM_EP-1:0]      fifo_init_i,
  input  logic [NUM_EP-1:0]      stall_req_i,
  output logic [NUM_EP*ST_W-1:0] ep_status_o,
  output logic [HS_W-1:0]        hs_o,
  output logic [NUM_EP-1:0]      full_irq_o,
  output logic [NUM_EP-1:0]      empty_irq_o
);
  logic [NUM_EP*HS_W-1:0] hs_all;
  tok_e                   tok_type;

  assign tok_type = tok_e'(tok_type_i);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_st_e st;
    hs_e    hs;
    usb_ep_slot #(.IS_CTRL(i == 0)) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (ev_ep_i == EP_W'(i)),
      .tok_valid_i (tok_valid_i),
      .tok_type_i  (tok_type),
      .rx_ok_i     (rx_ok_i),
      .rx_err_i    (rx_err_i),
      .tx_ack_i    (tx_ack_i),
      .tx_timeout_i(tx_timeout_i),
      .stage_tok_i (stage_tok_i),
      .stage_done_i(stage_done_i),
      .bus_reset_i (bus_reset_i),
      .cfg_i       (cfg_mask_i[i]),
      .fifo_init_i (fifo_init_i[i]),
      .stall_req_i (stall_req_i[i]),
      .st_o        (st),
      .hs_o        (hs),
      .full_o      (full_irq_o[i]),
      .empty_o     (empty_irq_o[i])
    );
    assign ep_status_o[i*ST_W +: ST_W] = st;
    assign hs_all[i*HS_W +: HS_W]      = hs;
  end

  usb_ep_hs_merge #(.N(NUM_EP), .W(HS_W)) i_hs_merge (
    .hs_all_i(hs_all),
    .hs_o    (hs_o)
  );

  // R12
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({full_irq_o, empty_irq_o}) <= 1);
endmodule

// File: tb/test_usb_ep_status_tracker.sv
`timescale 1ns/1ps
module test_usb_ep_status_tracker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  ev_ep_i = '0;
  logic        tok_valid_i = 1'b0;
  logic [1:0]  tok_type_i = '0;
  logic        rx_ok_i = 1'b0, rx_err_i = 1'b0, tx_ack_i = 1'b0, tx_timeout_i = 1'b0;
  logic        stage_tok_i = 1'b0, stage_done_i = 1'b0, bus_reset_i = 1'b0;
  logic [7:0]  cfg_mask_i = '0, fifo_init_i = '0, stall_req_i = '0;
  logic [23:0] ep_status_o;
  logic [1:0]  hs_o;
  logic [7:0]  full_irq_o, empty_irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  usb_ep_status_tracker i_usb_ep_status_tracker (.*);

  // kind: 0 idle,1 busrst,2 cfg,3 stall,4 fifo,5 token,6 rx ok,7 rx err,8 tx ack,9 tx to,10 stg tok,11 stg done
  // fields: kind[15:12] ep[11:9] tok[8:7] status[6:4] hs[3:2] full[1] empty[0]
  localparam int NV = 25;
  localparam logic [15:0] VEC [NV] = '{
    {4'd5, 3'd0, 2'd0, 3'd7, 2'd0, 1'b0, 1'b0},  // R2
    {4'd6, 3'd0, 2'd0, 3'd7, 2'd0, 1'b0, 1'b0},  // R2
    {4'd1, 3'd0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0},  // R3
    {4'd5, 3'd3, 2'd0, 3'd7, 2'd0, 1'b0, 1'b0},  // R3 others stay invalid
    {4'd2, 3'd3, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0},  // R4
    {4'd6, 3'd3, 2'd0, 3'd1, 2'd1, 1'b1, 1'b0},  // R8
    {4'd7, 3'd3, 2'd0, 3'd4, 2'd0, 1'b0, 1'b0},  // R9
    {4'd6, 3'd3, 2'd0, 3'd1, 2'd1, 1'b1, 1'b0},  // R9 retry
    {4'd9, 3'd3, 2'd0, 3'd3, 2'd0, 1'b0, 1'b0},  // R10
    {4'd8, 3'd3, 2'd0, 3'd0, 2'd0, 1'b0, 1'b1},  // R10
    {4'd3, 3'd3, 2'd0, 3'd6, 2'd0, 1'b0, 1'b0},  // R5
    {4'd5, 3'd3, 2'd1, 3'd6, 2'd3, 1'b0, 1'b0},  // R6
    {4'd5, 3'd3, 2'd2, 3'd6, 2'd0, 1'b0, 1'b0},  // R6 R7
    {4'd4, 3'd3, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0},  // R7
    {4'd3, 3'd0, 2'd0, 3'd6, 2'd0, 1'b0, 1'b0},  // R5
    {4'd5, 3'd0, 2'd0, 3'd6, 2'd3, 1'b0, 1'b0},  // R6
    {4'd4, 3'd0, 2'd0, 3'd6, 2'd0, 1'b0, 1'b0},  // R7 ignored on ep0
    {4'd5, 3'd0, 2'd2, 3'd0, 2'd0, 1'b0, 1'b0},  // R7
    {4'd10, 3'd0, 2'd0, 3'd5, 2'd0, 1'b0, 1'b0}, // R11
    {4'd6, 3'd0, 2'd0, 3'd5, 2'd2, 1'b0, 1'b0},  // R11 NAK
    {4'd11, 3'd0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0}, // R11
    {4'd10, 3'd3, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0}, // R11 non-ctrl ignores
    {4'd1, 3'd3, 2'd0, 3'd7, 2'd0, 1'b0, 1'b0},  // R3
    {4'd0, 3'd0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0},  // R3
    {4'd3, 3'd5, 2'd0, 3'd7, 2'd0, 1'b0, 1'b0}   // R2 stall ignored
  };
  localparam int VREQ [NV] = '{2,2,3,3,4,8,9,9,10,10,5,6,6,7,5,6,7,7,11,11,11,11,3,3,2};

  task automatic clear_in();
    tok_valid_i = 0; rx_ok_i = 0; rx_err_i = 0; tx_ack_i = 0; tx_timeout_i = 0;
    stage_tok_i = 0; stage_done_i = 0; bus_reset_i = 0;
    cfg_mask_i = '0; fifo_init_i = '0; stall_req_i = '0;
  endtask

  task automatic step(input int kind, input int ep, input int tok);
    @(negedge clk_i);
    ev_ep_i = 3'(ep); tok_type_i = 2'(tok);
    case (kind)
      1: bus_reset_i = 1;
      2: cfg_mask_i = 8'(1 << ep);
      3: stall_req_i = 8'(1 << ep);
      4: fifo_init_i = 8'(1 << ep);
      5: tok_valid_i = 1;
      6: rx_ok_i = 1;
      7: rx_err_i = 1;
      8: tx_ack_i = 1;
      9: tx_timeout_i = 1;
      10: stage_tok_i = 1;
      11: stage_done_i = 1;
      default: ;
    endcase
    @(negedge clk_i);
    clear_in();
  endtask

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", {hs_o, full_irq_o, empty_irq_o, ep_status_o}, {2'b0, 8'h0, 8'h0, 24'hFFFFFF});
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] w;
      logic [7:0] exp_full, exp_empty;
      w = VEC[v];
      step(int'(w[15:12]), int'(w[11:9]), int'(w[8:7]));
      exp_full  = w[1] ? 8'(1 << w[11:9]) : 8'h0;
      exp_empty = w[0] ? 8'(1 << w[11:9]) : 8'h0;
      check($sformatf("R%0d vec %0d", VREQ[v], v),
            {5'b0, ep_status_o[3*w[11:9] +: 3], hs_o, full_irq_o, empty_irq_o, 16'h0},
            {5'b0, w[6:4], w[3:2], exp_full, exp_empty, 16'h0});
    end

    // R12 pulse and handshake last one cycle; status holds
    step(2, 2, 0);
    step(6, 2, 0);
    check("R12 pulse", {hs_o, full_irq_o, 30'h0}, {2'b01, 8'h04, 30'h0});
    @(negedge clk_i);
    check("R12 clear", {hs_o, full_irq_o, 27'h0, ep_status_o[8:6]}, {2'b00, 8'h00, 27'h0, 3'd1});

    // R3 bus reset wins over stall request in same cycle
    @(negedge clk_i);
    bus_reset_i = 1; stall_req_i = 8'h01;
    @(negedge clk_i);
    clear_in();
    check("R3 prio", {16'h0, ep_status_o}, {16'h0, 24'hFFFFF8});

    // R1 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #2 check("R1 async", {16'h0, ep_status_o}, {16'h0, 24'hFFFFFF});
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R4 bit 0 of configuration ignored
    @(negedge clk_i);
    cfg_mask_i = 8'hFF;
    @(negedge clk_i);
    clear_in();
    check("R4 mask", {16'h0, ep_status_o}, {16'h0, 24'h000007});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule